// File: doc/BRIEF.md
# FIFO Burst Size Calculator

This block works out, for one audio transfer setup, how many words a DMA burst should move, what fill threshold the FIFO should be given, and roughly how many milliseconds of audio the FIFO holds. A controller drives the period length in bytes, the sample width, the channel count, the FIFO depth, the sample rate and the largest threshold the FIFO accepts, then pulses `start`. The block takes a snapshot of every input in that cycle and computes the result over many cycles, using a single shared restoring divider for every division and remainder.

In threshold mode the burst is chosen so that it splits the period into equal parts. The search starts at the smallest part count that keeps each part within the maximum threshold, and it counts upward until a count divides the period exactly. A search that only ends at the period length itself is rejected, because that would mean single-word bursts. In the other mode, multichannel streams move one frame per burst and mono streams use no burst grouping. The latency figure comes from the free FIFO room after one burst. It is first divided by the channel count, then scaled by 1000 and divided by the sample rate, and each division truncates.

Top module: `burst_size_calc`

## Requirements
- R1: After reset `busy`, `done`, `error`, `pkt_size`, `fifo_thresh` and `latency` are all 0.
- R2: The period length in words is `period_bytes` shifted right by 1 when `wide_samples` is 0 (16-bit samples) and by 2 when it is 1 (32-bit samples).
- R3: With `thr_mode` = 1 the part count starts at the ceiling of words / `max_thresh`. It is raised by one while it does not divide the word count and is still below it. `pkt_size` is the word count divided by the final part count.
- R4: If the part count in threshold mode ends equal to the word count, `error` is 1 and `pkt_size`, `fifo_thresh` and `latency` are all 0.
- R5: With `thr_mode` = 0, `pkt_size` equals `channels` when `channels` is above 1 and is 0 for one channel.
- R6: Without error, `fifo_thresh` equals `pkt_size`, or 1 when `pkt_size` is 0.
- R7: Without error, `latency` = ((`fifo_depth` − `pkt_size`) / `channels`) × 1000 / `sample_rate`, truncating at each division. The difference is taken as 0 when `pkt_size` exceeds `fifo_depth`.
- R8: `error` is set, with zero results, when `channels` or `sample_rate` is 0, or in threshold mode when `max_thresh` or the word count is 0.
- R9: `busy` rises in the cycle after an accepted `start`. `done` is a one-cycle pulse that comes one cycle after the results are written, and `busy` is low during it.
- R10: A `start` while `busy` is high is ignored: neither the running job nor its result is changed, and no second job follows.
- R11: Results stay unchanged from one `done` until the next job writes new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a job; all other inputs are sampled in this cycle |
| thr_mode | input | 1 | 1 = divisor search mode, 0 = frame-per-burst mode |
| wide_samples | input | 1 | 0 = 16-bit samples, 1 = 32-bit samples |
| period_bytes | input | W+2 | Period length in bytes |
| max_thresh | input | W | Largest FIFO threshold allowed |
| channels | input | CH_W | Channel count |
| fifo_depth | input | W | FIFO depth in words |
| sample_rate | input | RATE_W | Sample rate in Hz |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last job found no usable burst size or had a zero operand |
| pkt_size | output | W | Burst length in words |
| fifo_thresh | output | W | FIFO threshold to program |
| latency | output | W+11 | Latency estimate in milliseconds |

## Verification
The hardest case to reach is a long divisor search that runs all the way to the period length, because it only happens when the word count has no factor between the starting count and itself. The stimulus uses prime word counts with a small maximum threshold, for example 61 words with a limit of 2, which forces about thirty divider passes before the error. A composite count such as 119 words with a limit of 8 makes the search end on a divisor above the start value. A second `start` with different operands is pulsed in the middle of a long search, and the result and the later idle period show that it was dropped.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_CEIL, S_MODGO, S_MOD,
    S_LATGO, S_LATA, S_LATB, S_DONE
  } bsc_state_t;
endpackage

// File: rtl/bsc_divider.sv
module bsc_divider #(
  parameter int WIDTH = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  output logic             valid,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH:0]   acc_q;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             valid_q;
  logic [WIDTH:0]   shifted;
  logic             fits;

  always_comb begin
    shifted = {acc_q[WIDTH-1:0], q_q[WIDTH-1]};
    fits    = (shifted >= {1'b0, d_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      q_q     <= '0;
      d_q     <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go) begin
        acc_q <= '0;
        q_q   <= num;
        d_q   <= den;
        cnt_q <= CNT_W'(WIDTH);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) begin
          acc_q <= shifted - {1'b0, d_q};
          q_q   <= {q_q[WIDTH-2:0], 1'b1};
        end else begin
          acc_q <= shifted;
          q_q   <= {q_q[WIDTH-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid = valid_q;
  assign quo   = q_q;
  assign rem   = acc_q[WIDTH-1:0];

  AST_DIV_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rem < d_q)); // R7
  AST_DIV_NONZERO_DEN: assert property (@(posedge clk) disable iff (rst)
    go |-> (den != '0)); // R8
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
#(
  parameter int W      = 16,
  parameter int CH_W   = 5,
  parameter int RATE_W = 17,
  parameter int DW     = 27,
  parameter int SCALE  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              thr_mode,
  input  logic              wide_samples,
  input  logic [W+1:0]      period_bytes,
  input  logic [W-1:0]      max_thresh,
  input  logic [CH_W-1:0]   channels,
  input  logic [W-1:0]      fifo_depth,
  input  logic [RATE_W-1:0] sample_rate,
  output logic              div_go,
  output logic [DW-1:0]     div_num,
  output logic [DW-1:0]     div_den,
  input  logic              div_valid,
  input  logic [DW-1:0]     div_quo,
  input  logic [DW-1:0]     div_rem,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [W-1:0]      pkt_size,
  output logic [W-1:0]      fifo_thresh,
  output logic [DW-1:0]     latency
);
  bsc_state_t state;

  logic              mode_q;
  logic [W-1:0]      words_q;
  logic [W-1:0]      maxth_q;
  logic [CH_W-1:0]   ch_q;
  logic [W-1:0]      depth_q;
  logic [RATE_W-1:0] rate_q;
  logic [W-1:0]      parts_q;
  logic [W-1:0]      pkt_w;
  logic              go_q;
  logic [DW-1:0]     num_q;
  logic [DW-1:0]     den_q;
  logic              done_q;
  logic              err_q;
  logic [W-1:0]      pkt_q;
  logic [W-1:0]      thr_q;
  logic [DW-1:0]     lat_q;

  logic              bad_operands;
  logic [W-1:0]      room;
  logic [DW-1:0]     scaled;
  logic              rem_nonzero;

  always_comb begin
    bad_operands = (ch_q == '0) || (rate_q == '0) ||
                   (mode_q && ((maxth_q == '0) || (words_q == '0)));
    room         = (depth_q > pkt_w) ? (depth_q - pkt_w) : '0;
    scaled       = div_quo * DW'(SCALE);
    rem_nonzero  = (div_rem != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      mode_q  <= 1'b0;
      words_q <= '0;
      maxth_q <= '0;
      ch_q    <= '0;
      depth_q <= '0;
      rate_q  <= '0;
      parts_q <= '0;
      pkt_w   <= '0;
      go_q    <= 1'b0;
      num_q   <= '0;
      den_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      pkt_q   <= '0;
      thr_q   <= '0;
      lat_q   <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= (state == S_DONE);
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_q  <= thr_mode;
            words_q <= wide_samples ? period_bytes[W+1:2] : period_bytes[W:1];
            maxth_q <= max_thresh;
            ch_q    <= channels;
            depth_q <= fifo_depth;
            rate_q  <= sample_rate;
            state   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (bad_operands) begin
            err_q <= 1'b1;
            pkt_q <= '0;
            thr_q <= '0;
            lat_q <= '0;
            state <= S_DONE;
          end else if (mode_q) begin
            go_q  <= 1'b1;
            num_q <= DW'(words_q);
            den_q <= DW'(maxth_q);
            state <= S_CEIL;
          end else begin
            pkt_w <= (ch_q > CH_W'(1)) ? W'(ch_q) : '0;
            state <= S_LATGO;
          end
        end
        S_CEIL: begin
          if (div_valid) begin
            parts_q <= div_quo[W-1:0] + W'(rem_nonzero);
            state   <= S_MODGO;
          end
        end
        S_MODGO: begin
          go_q  <= 1'b1;
          num_q <= DW'(words_q);
          den_q <= DW'(parts_q);
          state <= S_MOD;
        end
        S_MOD: begin
          if (div_valid) begin
            if (rem_nonzero && (parts_q < words_q)) begin
              parts_q <= parts_q + 1'b1;
              state   <= S_MODGO;
            end else if (parts_q == words_q) begin
              err_q <= 1'b1;
              pkt_q <= '0;
              thr_q <= '0;
              lat_q <= '0;
              state <= S_DONE;
            end else begin
              pkt_w <= div_quo[W-1:0];
              state <= S_LATGO;
            end
          end
        end
        S_LATGO: begin
          go_q  <= 1'b1;
          num_q <= DW'(room);
          den_q <= DW'(ch_q);
          state <= S_LATA;
        end
        S_LATA: begin
          if (div_valid) begin
            go_q  <= 1'b1;
            num_q <= scaled;
            den_q <= DW'(rate_q);
            state <= S_LATB;
          end
        end
        S_LATB: begin
          if (div_valid) begin
            err_q <= 1'b0;
            pkt_q <= pkt_w;
            thr_q <= (pkt_w == '0) ? W'(1) : pkt_w;
            lat_q <= div_quo;
            state <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign div_go      = go_q;
  assign div_num     = num_q;
  assign div_den     = den_q;
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign error       = err_q;
  assign pkt_size    = pkt_q;
  assign fifo_thresh = thr_q;
  assign latency     = lat_q;

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERROR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> (pkt_size == '0 && fifo_thresh == '0 && latency == '0)); // R4
  AST_THRESH_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (fifo_thresh != '0)); // R6
  AST_PKT_SPLITS_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (done && !error && mode_q) |-> (pkt_size != '0 && (words_q % pkt_size) == '0)); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(pkt_size) && $stable(latency) && $stable(error))); // R11
endmodule

// File: rtl/burst_size_calc.sv
module burst_size_calc #(
  parameter int W      = 16,
  parameter int CH_W   = 5,
  parameter int RATE_W = 17,
  parameter int SCALE  = 1000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          thr_mode,
  input  logic                          wide_samples,
  input  logic [W+1:0]                  period_bytes,
  input  logic [W-1:0]                  max_thresh,
  input  logic [CH_W-1:0]               channels,
  input  logic [W-1:0]                  fifo_depth,
  input  logic [RATE_W-1:0]             sample_rate,
  output logic                          busy,
  output logic                          done,
  output logic                          error,
  output logic [W-1:0]                  pkt_size,
  output logic [W-1:0]                  fifo_thresh,
  output logic [W+$clog2(SCALE):0]      latency
);
  localparam int DW = W + $clog2(SCALE) + 1;

  logic          div_go;
  logic [DW-1:0] div_num;
  logic [DW-1:0] div_den;
  logic          div_valid;
  logic [DW-1:0] div_quo;
  logic [DW-1:0] div_rem;

  bsc_seq #(
    .W(W), .CH_W(CH_W), .RATE_W(RATE_W), .DW(DW), .SCALE(SCALE)
  ) i_seq (
    .clk(clk), .rst(rst), .start(start), .thr_mode(thr_mode),
    .wide_samples(wide_samples), .period_bytes(period_bytes),
    .max_thresh(max_thresh), .channels(channels), .fifo_depth(fifo_depth),
    .sample_rate(sample_rate), .div_go(div_go), .div_num(div_num),
    .div_den(div_den), .div_valid(div_valid), .div_quo(div_quo),
    .div_rem(div_rem), .busy(busy), .done(done), .error(error),
    .pkt_size(pkt_size), .fifo_thresh(fifo_thresh), .latency(latency)
  );

  bsc_divider #(.WIDTH(DW)) i_div (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .valid(div_valid), .quo(div_quo), .rem(div_rem)
  );
endmodule

// File: tb/test_burst_size_calc.sv
module test_burst_size_calc;
  localparam int W = 16, CH_W = 5, RATE_W = 17, LW = 27;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, thr_mode = 1'b0, wide_samples = 1'b0;
  logic [W+1:0] period_bytes = '0;
  logic [W-1:0] max_thresh = '0, fifo_depth = '0;
  logic [CH_W-1:0] channels = '0;
  logic [RATE_W-1:0] sample_rate = '0;
  logic busy, done, error;
  logic [W-1:0] pkt_size, fifo_thresh;
  logic [LW-1:0] latency;

  burst_size_calc i_burst_size_calc (
    .clk(clk), .rst(rst), .start(start), .thr_mode(thr_mode),
    .wide_samples(wide_samples), .period_bytes(period_bytes),
    .max_thresh(max_thresh), .channels(channels), .fifo_depth(fifo_depth),
    .sample_rate(sample_rate), .busy(busy), .done(done), .error(error),
    .pkt_size(pkt_size), .fifo_thresh(fifo_thresh), .latency(latency)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int exp_pk = 0, exp_th = 0, exp_lt = 0, exp_er = 0;
  int pend_pk, pend_th, pend_lt, pend_er;
  string tag = "R1";
  bit monitor_on = 1'b0;
  bit saw_done = 1'b0;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(input bit thr, input bit wide, input int pb, input int mth,
                       input int ch, input int depth, input int rate);
    int words, d, room;
    words = wide ? pb / 4 : pb / 2;                       // R2
    pend_er = (ch == 0 || rate == 0 || (thr && (mth == 0 || words == 0))) ? 1 : 0; // R8
    pend_pk = 0;
    if (pend_er == 0) begin
      if (thr) begin                                      // R3
        d = words / mth + ((words % mth) != 0 ? 1 : 0);
        while ((words % d) != 0 && d < words) d++;
        if (d == words) pend_er = 1;                      // R4
        else pend_pk = words / d;
      end else pend_pk = (ch > 1) ? ch : 0;               // R5
    end
    if (pend_er != 0) begin
      pend_pk = 0; pend_th = 0; pend_lt = 0;
    end else begin
      pend_th = (pend_pk == 0) ? 1 : pend_pk;             // R6
      room = (depth > pend_pk) ? depth - pend_pk : 0;     // R7
      pend_lt = ((room / ch) * 1000) / rate;
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (monitor_on) begin
      if (done) begin
        exp_pk = pend_pk; exp_th = pend_th; exp_lt = pend_lt; exp_er = pend_er;
        saw_done = 1'b1;
        check("R9", int'(busy), 0, "busy during done");
      end
      if (!busy) begin
        check(tag, int'(error), exp_er, "error");
        check(tag, int'(pkt_size), exp_pk, "pkt_size");
        check(tag, int'(fifo_thresh), exp_th, "fifo_thresh");
        check(tag, int'(latency), exp_lt, "latency");
      end
    end
  end

  task automatic launch(input string req, input bit thr, input bit wide, input int pb,
                        input int mth, input int ch, input int depth, input int rate);
    @(negedge clk);
    thr_mode = thr; wide_samples = wide; period_bytes = (W+2)'(pb);
    max_thresh = W'(mth); channels = CH_W'(ch); fifo_depth = W'(depth);
    sample_rate = RATE_W'(rate);
    model(thr, wide, pb, mth, ch, depth, rate);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tag = req;
    saw_done = 1'b0;
    check("R9", int'(busy), 1, "busy after start");
  endtask

  task automatic wait_done();
    int n = 0;
    while (!saw_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!saw_done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog: actual=no done expected=done");
    end
    @(negedge clk);
  endtask

  task automatic job(input string req, input bit thr, input bit wide, input int pb,
                     input int mth, input int ch, input int depth, input int rate);
    launch(req, thr, wide, pb, mth, ch, depth, rate);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(done), 0, "done after reset");
    monitor_on = 1'b1;
    job("R3", 1, 0, 240, 64, 2, 1280, 48000);   // 120 words -> 2 parts, pkt 60, lat 12
    job("R2", 1, 1, 400, 30, 2, 1280, 48000);   // 32-bit: 100 words -> 4 parts, pkt 25
    job("R3", 1, 0, 238, 8, 2, 1280, 48000);    // 119 words: 15,16 fail, 17 -> pkt 7
    job("R4", 1, 0, 14, 2, 2, 1280, 48000);     // 7 words prime -> error
    job("R4", 1, 0, 2, 4, 1, 128, 8000);        // 1 word -> error
    job("R5", 0, 0, 256, 0, 1, 128, 8000);      // mono: pkt 0, thr 1, lat 16
    job("R5", 0, 0, 256, 0, 4, 128, 44100);     // pkt 4, lat 0
    job("R7", 0, 1, 256, 0, 2, 1280, 8000);     // pkt 2, lat 79
    job("R7", 1, 0, 240, 64, 2, 32, 48000);     // pkt 60 > depth -> lat 0
    job("R8", 1, 0, 240, 0, 2, 1280, 48000);    // zero max threshold
    job("R8", 0, 0, 240, 4, 0, 1280, 48000);    // zero channels
    job("R8", 0, 0, 240, 4, 2, 1280, 0);        // zero rate
    job("R8", 1, 1, 2, 4, 2, 1280, 48000);      // zero words
    // R10: a long search (61 words, limit 2) with a second start in mid-run
    launch("R10", 1, 0, 122, 2, 2, 1280, 48000);
    repeat (40) @(negedge clk);
    thr_mode = 1'b0; channels = 5'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check("R10", int'(busy), 0, "no second job after ignored start");
    check("R11", int'(pkt_size), exp_pk, "held result");
    job("R6", 0, 0, 64, 0, 1, 64, 96000);       // pkt 0 -> threshold 1, lat 0
    monitor_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL R9 global watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule